// File: doc/BRIEF.md
# Producer-Consumer Latency Scoreboard

This block keeps, for every architectural register, the class of the most recent instruction that wrote it and the number of cycles since that instruction issued. Each operand of a candidate consumer instruction asks one check port whether it may issue now. The port gives the register number, the consumer's class and the way the operand is used. The answer comes from a latency rule that takes both sides of the dependency into account, not only the producer. Several pairs have a latency of zero, so the consumer may issue in the same cycle as its producer.

Issue logic drives one write port per issue slot for each instruction it sends, and samples the check ports before it issues. A write and a check in the same cycle interact. The check sees the new producer at zero elapsed cycles, so a zero-latency consumer is ready and every other consumer waits.

Top module: `latencyScoreboard`

## Requirements
- R1: After reset, and for any register without a pending producer, every check port reports ready whatever the consumer class and role; reset drops all pending producers.
- R2: Producer class codes on `wrClass` are 0 none (store or branch), 1 ALU, 2 move, 3 multiply, 4 accumulate, 5 long multiply, 6 one-cycle multiply, 7 long accumulate, 8 single or double load, 9 three or four register load, 10 call; codes 11 to 15 act as none. Their default latencies are, in that order, 0, 2, 1, 6, 6, 7, 5, 6, 3, 5 and 32.
- R3: A move feeding an ALU consumer's normal operand has latency 0, and that consumer is ready in the producer's own issue cycle.
- R4: An ALU result feeding an ALU consumer's normal operand has latency 1.
- R5: For an ALU consumer's normal operand, every multiply class (codes 3 to 7) has latency 4, a single or double load has latency 2, and a load multiple has latency 4.
- R6: An accumulate consumer's accumulator operand (consumer class accumulate, role normal) sees latency 1 from multiply, accumulate and one-cycle multiply producers. Long multiply and long accumulate producers keep their default latency.
- R7: A store-data operand has latency 0 from ALU and move producers. A store-address operand uses the default latency.
- R8: An operand is ready exactly when the cycles elapsed since its producer issued (0 in the issue cycle) are at least the pair latency. The elapsed count saturates at 32, so a call producer releases its consumers 32 cycles after issue.
- R9: A new write to a register replaces the older producer. When several slots write one register in the same cycle, the highest-numbered slot wins.
- R10: Consumer class codes on `chkCons` are 0 ALU, 1 accumulate, 2 store, 3 other. Role codes on `chkRole` are 0 normal, 1 early shifter input, 2 store data, 3 store address. An early operand always uses the default latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | NUM_WR | Per issue slot: records a new producer |
| wrReg | input | NUM_WR*REG_W | Per slot destination register |
| wrClass | input | NUM_WR*4 | Per slot producer class code |
| chkReg | input | NUM_CHK*REG_W | Per check port source register |
| chkCons | input | NUM_CHK*2 | Per check port consumer class code |
| chkRole | input | NUM_CHK*2 | Per check port operand role code |
| chkReady | output | NUM_CHK | Per check port: operand may issue this cycle |

## Verification
A wrong stored class or elapsed count shows up as a ready flag that rises too early or too late on any port that reads the register. The error is visible within the pair latency of the write, at most 32 cycles, and in the same cycle when the latency is zero. The sweep writes every producer class and watches every consumer class and role cycle by cycle from issue to saturation. Any misplaced edge of the ready flag is therefore exposed at its own cycle. A lost replacement or a wrong slot priority shows up in the cycle that follows the write.

// File: rtl/sbPkg.sv
package sbPkg;

  localparam int CLS_W = 4;
  localparam int LAT_W = 6;

  typedef enum logic [CLS_W-1:0] {
    PC_NONE = 4'd0,
    PC_ALU  = 4'd1,
    PC_MOV  = 4'd2,
    PC_MUL  = 4'd3,
    PC_MLA  = 4'd4,
    PC_MULL = 4'd5,
    PC_MULW = 4'd6,
    PC_MLAL = 4'd7,
    PC_LD12 = 4'd8,
    PC_LD34 = 4'd9,
    PC_CALL = 4'd10
  } prodClass_e;

  typedef enum logic [1:0] {
    CC_ALU   = 2'd0,
    CC_MAC   = 2'd1,
    CC_STORE = 2'd2,
    CC_OTHER = 2'd3
  } consClass_e;

  typedef enum logic [1:0] {
    RL_NORMAL = 2'd0,
    RL_EARLY  = 2'd1,
    RL_STDATA = 2'd2,
    RL_STADDR = 2'd3
  } operandRole_e;

  // Per-register strobe from control to datapath
  typedef struct packed {
    logic       load;
    prodClass_e cls;
  } regStrobe_t;

  function automatic logic [LAT_W-1:0] pairLatency(prodClass_e p, consClass_e c, operandRole_e r);
    logic [LAT_W-1:0] lat;
    case (p)
      PC_ALU:  lat = 6'd2;
      PC_MOV:  lat = 6'd1;
      PC_MUL:  lat = 6'd6;
      PC_MLA:  lat = 6'd6;
      PC_MULL: lat = 6'd7;
      PC_MULW: lat = 6'd5;
      PC_MLAL: lat = 6'd6;
      PC_LD12: lat = 6'd3;
      PC_LD34: lat = 6'd5;
      PC_CALL: lat = 6'd32;
      default: lat = 6'd0;
    endcase
    if (r == RL_STDATA && (p == PC_ALU || p == PC_MOV)) begin
      lat = 6'd0;
    end else if (c == CC_ALU && r == RL_NORMAL) begin
      case (p)
        PC_MOV:  lat = 6'd0;
        PC_ALU:  lat = 6'd1;
        PC_MUL, PC_MLA, PC_MULL, PC_MULW, PC_MLAL: lat = 6'd4;
        PC_LD12: lat = 6'd2;
        PC_LD34: lat = 6'd4;
        default: lat = lat;
      endcase
    end else if (c == CC_MAC && r == RL_NORMAL &&
                 (p == PC_MUL || p == PC_MLA || p == PC_MULW)) begin
      lat = 6'd1;
    end
    return lat;
  endfunction

endpackage

// File: rtl/sbControl.sv
module sbControl
  import sbPkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int NUM_WR   = 2,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_WR-1:0]       wrEn,
  input  logic [NUM_WR*REG_W-1:0] wrReg,
  input  logic [NUM_WR*CLS_W-1:0] wrClass,
  output regStrobe_t              strobe [NUM_REGS]
);

  // Later slots override earlier ones: highest slot wins (R9)
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      strobe[r].load = 1'b0;
      strobe[r].cls  = PC_NONE;
      for (int w = 0; w < NUM_WR; w++) begin
        if (wrEn[w] && wrReg[w*REG_W +: REG_W] == REG_W'(r)) begin
          strobe[r].load = 1'b1;
          strobe[r].cls  = prodClass_e'(wrClass[w*CLS_W +: CLS_W]);
        end
      end
    end
  end

endmodule

// File: rtl/sbDatapath.sv
module sbDatapath
  import sbPkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int SAT_LIMIT = 32,
  parameter int CNT_W     = $clog2(SAT_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe   [NUM_REGS],
  output logic [NUM_REGS-1:0] validVec,
  output prodClass_e       clsArr   [NUM_REGS],
  output logic [CNT_W-1:0] cntArr   [NUM_REGS]
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validVec[r] <= 1'b0;
        clsArr[r]   <= PC_NONE;
        cntArr[r]   <= '0;
      end else if (strobe[r].load) begin
        validVec[r] <= 1'b1;
        clsArr[r]   <= strobe[r].cls;
        cntArr[r]   <= CNT_W'(1);
      end else if (validVec[r] && cntArr[r] < CNT_W'(SAT_LIMIT)) begin
        cntArr[r]   <= cntArr[r] + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sbCheck.sv
module sbCheck
  import sbPkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = $clog2(NUM_REGS),
  parameter int CNT_W    = 6
) (
  input  logic [REG_W-1:0]    chkReg,
  input  consClass_e          cons,
  input  operandRole_e        role,
  input  regStrobe_t          strobe   [NUM_REGS],
  input  logic [NUM_REGS-1:0] validVec,
  input  prodClass_e          clsArr   [NUM_REGS],
  input  logic [CNT_W-1:0]    cntArr   [NUM_REGS],
  output logic                ready
);

  prodClass_e       prodCls;
  logic [CNT_W-1:0] elapsed;
  logic             pending;
  logic [LAT_W-1:0] need;

  always_comb begin
    if (strobe[chkReg].load) begin
      prodCls = strobe[chkReg].cls;
      elapsed = '0;
      pending = 1'b1;
    end else begin
      prodCls = clsArr[chkReg];
      elapsed = cntArr[chkReg];
      pending = validVec[chkReg];
    end
    need  = pairLatency(prodCls, cons, role);
    ready = !pending || (int'(elapsed) >= int'(need));
  end

endmodule

// File: rtl/latencyScoreboard.sv
module latencyScoreboard
  import sbPkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int NUM_WR    = 2,
  parameter int NUM_CHK   = 4,
  parameter int SAT_LIMIT = 32,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int CNT_W    = $clog2(SAT_LIMIT + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_WR-1:0]        wrEn,
  input  logic [NUM_WR*REG_W-1:0]  wrReg,
  input  logic [NUM_WR*4-1:0]      wrClass,
  input  logic [NUM_CHK*REG_W-1:0] chkReg,
  input  logic [NUM_CHK*2-1:0]     chkCons,
  input  logic [NUM_CHK*2-1:0]     chkRole,
  output logic [NUM_CHK-1:0]       chkReady
);

  regStrobe_t          strobe [NUM_REGS];
  logic [NUM_REGS-1:0] validVec;
  prodClass_e          clsArr [NUM_REGS];
  logic [CNT_W-1:0]    cntArr [NUM_REGS];
  logic [NUM_REGS*CNT_W-1:0] cntFlat;
  logic [NUM_REGS*CLS_W-1:0] clsFlat;

  sbControl #(.NUM_REGS(NUM_REGS), .NUM_WR(NUM_WR), .REG_W(REG_W)) uCtrl (
    .wrEn(wrEn), .wrReg(wrReg), .wrClass(wrClass), .strobe(strobe)
  );

  sbDatapath #(.NUM_REGS(NUM_REGS), .SAT_LIMIT(SAT_LIMIT), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .validVec(validVec), .clsArr(clsArr), .cntArr(cntArr)
  );

  for (genvar c = 0; c < NUM_CHK; c++) begin : gPort
    sbCheck #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .CNT_W(CNT_W)) uChk (
      .chkReg(chkReg[c*REG_W +: REG_W]),
      .cons(consClass_e'(chkCons[c*2 +: 2])),
      .role(operandRole_e'(chkRole[c*2 +: 2])),
      .strobe(strobe), .validVec(validVec), .clsArr(clsArr), .cntArr(cntArr),
      .ready(chkReady[c])
    );
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : gFlat
    assign cntFlat[r*CNT_W +: CNT_W] = cntArr[r];
    assign clsFlat[r*CLS_W +: CLS_W] = clsArr[r];
  end

endmodule

// File: rtl/sbCheckerAsserts.sv
module sbCheckerAsserts
  import sbPkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int NUM_WR    = 2,
  parameter int NUM_CHK   = 4,
  parameter int SAT_LIMIT = 32,
  parameter int REG_W     = 4,
  parameter int CNT_W     = 6
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_WR-1:0]         wrEn,
  input logic [NUM_WR*REG_W-1:0]   wrReg,
  input logic [NUM_CHK*REG_W-1:0]  chkReg,
  input logic [NUM_CHK-1:0]        chkReady,
  input logic [NUM_REGS-1:0]       validVec,
  input logic [NUM_REGS*CNT_W-1:0] cntFlat,
  input logic [NUM_REGS*CLS_W-1:0] clsFlat
);

  logic [NUM_REGS-1:0] wrHit;
  always_comb begin
    wrHit = '0;
    for (int w = 0; w < NUM_WR; w++)
      if (wrEn[w]) wrHit[wrReg[w*REG_W +: REG_W]] = 1'b1;
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> validVec == '0);

  for (genvar r = 0; r < NUM_REGS; r++) begin : gReg
    a_r8_count_cap: assert property (@(posedge clk) disable iff (!rstN)
      int'(cntFlat[r*CNT_W +: CNT_W]) <= SAT_LIMIT);
    a_r9_fresh_entry: assert property (@(posedge clk) disable iff (!rstN)
      wrHit[r] |=> validVec[r] && cntFlat[r*CNT_W +: CNT_W] == CNT_W'(1));
    a_r8_count_advances: assert property (@(posedge clk) disable iff (!rstN)
      (validVec[r] && !wrHit[r] && int'(cntFlat[r*CNT_W +: CNT_W]) < SAT_LIMIT)
      |=> cntFlat[r*CNT_W +: CNT_W] == $past(cntFlat[r*CNT_W +: CNT_W]) + CNT_W'(1));
  end

  for (genvar c = 0; c < NUM_CHK; c++) begin : gPort
    a_r1_idle_ready: assert property (@(posedge clk) disable iff (!rstN)
      (!validVec[chkReg[c*REG_W +: REG_W]] && !wrHit[chkReg[c*REG_W +: REG_W]])
      |-> chkReady[c]);
    a_r8_call_wait: assert property (@(posedge clk) disable iff (!rstN)
      (validVec[chkReg[c*REG_W +: REG_W]] && !wrHit[chkReg[c*REG_W +: REG_W]] &&
       clsFlat[chkReg[c*REG_W +: REG_W]*CLS_W +: CLS_W] == CLS_W'(PC_CALL) &&
       int'(cntFlat[chkReg[c*REG_W +: REG_W]*CNT_W +: CNT_W]) < 32)
      |-> !chkReady[c]);
  end

endmodule

bind latencyScoreboard sbCheckerAsserts #(
  .NUM_REGS(NUM_REGS), .NUM_WR(NUM_WR), .NUM_CHK(NUM_CHK),
  .SAT_LIMIT(SAT_LIMIT), .REG_W(REG_W), .CNT_W(CNT_W)
) uAsserts (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrReg(wrReg), .chkReg(chkReg),
  .chkReady(chkReady), .validVec(validVec), .cntFlat(cntFlat), .clsFlat(clsFlat)
);

// File: tb/tb_latencyScoreboard.sv
module tb_latencyScoreboard;

  localparam int NUM_REGS = 16;
  localparam int NUM_WR   = 2;
  localparam int NUM_CHK  = 4;
  localparam int REG_W    = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_WR-1:0]        wrEn = '0;
  logic [NUM_WR*REG_W-1:0]  wrReg = '0;
  logic [NUM_WR*4-1:0]      wrClass = '0;
  logic [NUM_CHK*REG_W-1:0] chkReg = '0;
  logic [NUM_CHK*2-1:0]     chkCons = '0;
  logic [NUM_CHK*2-1:0]     chkRole = '0;
  logic [NUM_CHK-1:0]       chkReady;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  latencyScoreboard dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrReg(wrReg), .wrClass(wrClass),
    .chkReg(chkReg), .chkCons(chkCons), .chkRole(chkRole), .chkReady(chkReady)
  );

  function automatic int expLat(int p, int c, int r);
    int base;
    case (p)
      1: base = 2;  2: base = 1;  3: base = 6;  4: base = 6;  5: base = 7;
      6: base = 5;  7: base = 6;  8: base = 3;  9: base = 5;  10: base = 32;
      default: base = 0;
    endcase
    if (r == 2 && (p == 1 || p == 2)) return 0;            // R7
    if (c == 0 && r == 0) begin                             // R3 R4 R5
      if (p == 2) return 0;
      if (p == 1) return 1;
      if (p >= 3 && p <= 7) return 4;
      if (p == 8) return 2;
      if (p == 9) return 4;
    end
    if (c == 1 && r == 0 && (p == 3 || p == 4 || p == 6)) return 1; // R6
    return base;                                            // R2 R10
  endfunction

  task automatic check(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string reqOf(int p, int c, int r);
    if (r == 2 && (p == 1 || p == 2)) return "R7";
    if (c == 0 && r == 0 && p == 2) return "R3";
    if (c == 0 && r == 0 && p == 1) return "R4";
    if (c == 0 && r == 0 && p >= 3 && p <= 9) return "R5";
    if (c == 1 && r == 0) return "R6";
    if (p == 10) return "R8";
    if (r == 1) return "R10";
    return "R2";
  endfunction

  task automatic setPorts(int reg_, int cons);
    for (int k = 0; k < NUM_CHK; k++) begin
      chkReg[k*REG_W +: REG_W] = REG_W'(reg_);
      chkCons[k*2 +: 2] = 2'(cons);
      chkRole[k*2 +: 2] = 2'(k);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrEn = '0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    // R1: reset state, every register, every consumer class
    for (int g = 0; g < NUM_REGS; g++) begin
      for (int c = 0; c < 4; c++) begin
        setPorts(g, c);
        #2;
        for (int k = 0; k < NUM_CHK; k++) check("R1", chkReady[k], 1'b1);
      end
    end

    // Sweep: every producer class x consumer class x role, elapsed 0..34 (R2..R8, R10)
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 4; c++) begin
        int g;
        int slot;
        g = (p * 4 + c) % NUM_REGS;
        slot = (p + c) % NUM_WR;
        @(negedge clk);
        wrEn = '0;
        wrEn[slot] = 1'b1;
        wrReg[slot*REG_W +: REG_W] = REG_W'(g);
        wrClass[slot*4 +: 4] = 4'(p);
        setPorts(g, c);
        for (int e = 0; e <= 34; e++) begin
          #2;
          for (int k = 0; k < NUM_CHK; k++)
            check(reqOf(p, c, k), chkReady[k], e >= expLat(p, c, k));
          @(negedge clk);
          wrEn = '0;
        end
      end
    end

    // R9: replacement of an older producer
    doReset();
    wrEn[0] = 1'b1; wrReg[0 +: REG_W] = 4'd3; wrClass[0 +: 4] = 4'd5;
    setPorts(3, 0);
    @(negedge clk); wrEn = '0;
    @(negedge clk);
    #2 check("R9", chkReady[0], 1'b0);
    @(negedge clk);
    wrEn[1] = 1'b1; wrReg[REG_W +: REG_W] = 4'd3; wrClass[4 +: 4] = 4'd2;
    #2 check("R9", chkReady[0], 1'b1);
    @(negedge clk); wrEn = '0;
    #2 check("R9", chkReady[0], 1'b1);
    wrEn[0] = 1'b1; wrClass[0 +: 4] = 4'd10;
    @(negedge clk); wrEn = '0;
    repeat (10) @(negedge clk);
    #2 check("R9", chkReady[0], 1'b0);

    // R9: same-cycle slot priority
    doReset();
    setPorts(6, 0);
    wrEn = 2'b11;
    wrReg = {4'd6, 4'd6};
    wrClass = {4'd2, 4'd10};   // slot1 move, slot0 call
    #2 check("R9", chkReady[0], 1'b1);
    @(negedge clk); wrEn = '0;
    #2 check("R9", chkReady[0], 1'b1);
    wrEn = 2'b11;
    wrClass = {4'd10, 4'd2};   // slot1 call, slot0 move
    #2 check("R9", chkReady[0], 1'b0);
    @(negedge clk); wrEn = '0;
    #2 check("R9", chkReady[0], 1'b0);

    // R1: other registers unaffected, reset drops pending producer
    setPorts(5, 0);
    #2 check("R1", chkReady[0], 1'b1);
    doReset();
    setPorts(6, 0);
    #2 check("R1", chkReady[0], 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule